// File: doc/BRIEF.md
# Stream-to-bus write master bridge

This block takes beats from a packet stream and issues each one as a single write on a memory-mapped bus, where the bridge is the bus master. Each beat carries a payload, packet start and end markers, an empty-symbol count, an error code and a channel number. The channel number becomes the write address. The payload and every sideband field are packed into one wide write word, so the slave receives the whole beat in one transfer. Data only moves from the stream into the bus.

The handshakes map directly onto each other. The bus write strobe follows stream valid, and stream ready is the inverse of the bus waitrequest. A parameter chooses between two forms. One is a zero-latency pass-through. The other is a single output register that cuts the data and address timing paths and still keeps both handshakes legal.

The register stage is a two-state machine:
- `STG_EMPTY` holds nothing, keeps write low and keeps ready high.
- `STG_HOLD` presents its stored beat with write high.

It has four transitions:
- *load*: `STG_EMPTY` to `STG_HOLD` on an accepted beat.
- *reload*: stays in `STG_HOLD` when the held beat drains and a new beat is taken in the same cycle.
- *stall*: stays in `STG_HOLD` while waitrequest is high.
- *drain*: `STG_HOLD` to `STG_EMPTY` when the held beat completes and no new beat arrives.

Top module: `st2mm_wr_bridge`

## Requirements
- R1: With `REG_OUT=1`, a beat taken on a clock edge (`snk_valid` and `snk_ready` both high) shows up with `mst_write` high from that edge on. With `REG_OUT=0`, `mst_write` equals `snk_valid` in the same cycle.
- R2: Whenever `mst_write` is high, `snk_ready` equals the inverse of `mst_waitrequest`.
- R3: The low `DATA_W` bits of `mst_writedata` carry the payload of the beat being written.
- R4: `mst_address` carries the beat's channel number, zero-extended to `ADDR_W` bits.
- R5: `mst_writedata` is packed from the LSB up in this order: payload, start marker, end marker, empty count, error code, channel. With the default widths this gives:
  - data in [31:0]
  - start in [32]
  - end in [33]
  - empty in [35:34]
  - error in [37:36]
  - channel in [41:38]
- R6: A bus write completes on an edge where `mst_write` is high and `mst_waitrequest` is low. While `mst_waitrequest` is high, `mst_write`, `mst_address` and `mst_writedata` hold their values into the next cycle.
- R7: With `REG_OUT=1`, a new beat is taken only when the stage is empty, or when its held beat completes in that same cycle. An empty stage takes a beat even while `mst_waitrequest` is high.
- R8: With `REG_OUT=1`, reset (`rst_n` low, asynchronous) empties the stage. During and after reset, `mst_write` is low and `snk_ready` is high.
- R9: With `REG_OUT=0`, the block stores nothing:
  - address and write word follow the stream inputs in the same cycle;
  - `snk_ready` equals the inverse of `mst_waitrequest` even while `snk_valid` is low.
- R10: With `REG_OUT=1` and `mst_waitrequest` held low, the bridge takes and writes one beat per clock cycle with no bubbles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| snk_valid | input | 1 | Stream beat present |
| snk_ready | output | 1 | Bridge can take the beat |
| snk_data | input | DATA_W | Stream payload |
| snk_sop | input | 1 | First beat of a packet |
| snk_eop | input | 1 | Last beat of a packet |
| snk_empty | input | EMPTY_W | Unused symbols in the last beat |
| snk_error | input | ERR_W | Error code of the beat |
| snk_channel | input | CHAN_W | Channel number of the beat |
| mst_write | output | 1 | Bus write request |
| mst_address | output | ADDR_W | Bus word address (channel) |
| mst_writedata | output | DATA_W+2+EMPTY_W+ERR_W+CHAN_W | Packed payload and sideband |
| mst_waitrequest | input | 1 | Slave stalls the current write |

## Verification
The bench builds two instances with the default widths (32-bit payload, 2-bit empty, 2-bit error, 4-bit channel, 8-bit address), which makes every field boundary of the 42-bit write word visible:
- one instance with `REG_OUT=1`, driven by a table of cycles that walks every register-stage transition: load, stall over two cycles, reload under back-to-back traffic, drain, and an empty stage taking a beat while the slave stalls;
- a second instance with `REG_OUT=0`, checked for same-cycle mapping, stall hold and ready tracking waitrequest while the stream is idle.

A reset applied while a write is stalled shows that the held beat is dropped at once.

// File: rtl/st2mm_pkg.sv
package st2mm_pkg;

    // Occupancy of the optional output register stage
    typedef enum logic [0:0] {
        STG_EMPTY = 1'b0,
        STG_HOLD  = 1'b1
    } stg_state_e;

    // Width of the packed write word: payload, two packet markers, empty, error, channel
    function automatic int word_width(input int data_w, input int empty_w,
                                      input int err_w, input int chan_w);
        return data_w + 2 + empty_w + err_w + chan_w;
    endfunction

endpackage

// File: rtl/st2mm_pack.sv
module st2mm_pack #(
    parameter int DATA_W  = 32,
    parameter int EMPTY_W = 2,
    parameter int ERR_W   = 2,
    parameter int CHAN_W  = 4,
    parameter int ADDR_W  = 8,
    localparam int WD_W   = st2mm_pkg::word_width(DATA_W, EMPTY_W, ERR_W, CHAN_W)
) (
    input  logic [DATA_W-1:0]  data,
    input  logic               sop,
    input  logic               eop,
    input  logic [EMPTY_W-1:0] empty,
    input  logic [ERR_W-1:0]   error,
    input  logic [CHAN_W-1:0]  channel,
    output logic [WD_W-1:0]    word,
    output logic [ADDR_W-1:0]  addr
);
    // Field positions inside the write word, lowest first
    localparam int SOP_POS = DATA_W;
    localparam int EOP_POS = DATA_W + 1;
    localparam int EMP_LO  = DATA_W + 2;
    localparam int ERR_LO  = EMP_LO + EMPTY_W;
    localparam int CH_LO   = ERR_LO + ERR_W;

    assign word[DATA_W-1:0]            = data;
    assign word[SOP_POS]               = sop;
    assign word[EOP_POS]               = eop;
    assign word[ERR_LO-1:EMP_LO]       = empty;
    assign word[CH_LO-1:ERR_LO]        = error;
    assign word[WD_W-1:CH_LO]          = channel;

    // The channel number is the word address; widen it when the bus is wider
    generate
        if (ADDR_W > CHAN_W) begin : g_addr_wide
            assign addr = {{(ADDR_W-CHAN_W){1'b0}}, channel};
        end else begin : g_addr_same
            assign addr = channel[ADDR_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/st2mm_stage.sv
module st2mm_stage
    import st2mm_pkg::*;
#(
    parameter int BEAT_W  = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BEAT_W-1:0] in_beat,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [BEAT_W-1:0] out_beat,
    output logic              out_valid,
    input  logic              out_wait
);
    generate
        if (REG_OUT) begin : g_reg
            stg_state_e        state_q;
            stg_state_e        state_d;
            logic [BEAT_W-1:0] beat_q;
            logic              take;
            logic              drain;

            assign take  = in_valid && in_ready;
            assign drain = out_valid && !out_wait;

            // State register
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    state_q <= STG_EMPTY;
                end else begin
                    state_q <= state_d;
                end
            end

            // Transitions: load, reload, stall, drain
            always_comb begin
                state_d = state_q;
                unique case (state_q)
                    STG_EMPTY: begin
                        if (take) begin
                            state_d = STG_HOLD;
                        end
                    end
                    STG_HOLD: begin
                        if (!take && drain) begin
                            state_d = STG_EMPTY;
                        end
                    end
                    default: state_d = STG_EMPTY;
                endcase
            end

            // Outputs: an empty stage always takes, a full one only as it drains
            always_comb begin
                unique case (state_q)
                    STG_EMPTY: begin
                        out_valid = 1'b0;
                        in_ready  = 1'b1;
                    end
                    STG_HOLD: begin
                        out_valid = 1'b1;
                        in_ready  = !out_wait;
                    end
                    default: begin
                        out_valid = 1'b0;
                        in_ready  = 1'b0;
                    end
                endcase
            end

            // Beat storage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    beat_q <= '0;
                end else if (take) begin
                    beat_q <= in_beat;
                end
            end

            assign out_beat = beat_q;
        end else begin : g_thru
            assign out_valid = in_valid;
            assign in_ready  = !out_wait;
            assign out_beat  = in_beat;
        end
    endgenerate

endmodule

// File: rtl/st2mm_wr_bridge.sv
module st2mm_wr_bridge #(
    parameter int DATA_W  = 32,
    parameter int EMPTY_W = 2,
    parameter int ERR_W   = 2,
    parameter int CHAN_W  = 4,
    parameter int ADDR_W  = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    snk_valid,
    output logic                                    snk_ready,
    input  logic [DATA_W-1:0]                       snk_data,
    input  logic                                    snk_sop,
    input  logic                                    snk_eop,
    input  logic [EMPTY_W-1:0]                      snk_empty,
    input  logic [ERR_W-1:0]                        snk_error,
    input  logic [CHAN_W-1:0]                       snk_channel,
    output logic                                    mst_write,
    output logic [ADDR_W-1:0]                       mst_address,
    output logic [DATA_W+2+EMPTY_W+ERR_W+CHAN_W-1:0] mst_writedata,
    input  logic                                    mst_waitrequest
);
    localparam int WD_W   = st2mm_pkg::word_width(DATA_W, EMPTY_W, ERR_W, CHAN_W);
    localparam int BEAT_W = ADDR_W + WD_W;

    logic [WD_W-1:0]   packed_word;
    logic [ADDR_W-1:0] packed_addr;
    logic [BEAT_W-1:0] stage_out;

    st2mm_pack #(
        .DATA_W (DATA_W),
        .EMPTY_W(EMPTY_W),
        .ERR_W  (ERR_W),
        .CHAN_W (CHAN_W),
        .ADDR_W (ADDR_W)
    ) u_pack (
        .data   (snk_data),
        .sop    (snk_sop),
        .eop    (snk_eop),
        .empty  (snk_empty),
        .error  (snk_error),
        .channel(snk_channel),
        .word   (packed_word),
        .addr   (packed_addr)
    );

    st2mm_stage #(
        .BEAT_W (BEAT_W),
        .REG_OUT(REG_OUT)
    ) u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_beat  ({packed_addr, packed_word}),
        .in_valid (snk_valid),
        .in_ready (snk_ready),
        .out_beat (stage_out),
        .out_valid(mst_write),
        .out_wait (mst_waitrequest)
    );

    assign mst_address   = stage_out[BEAT_W-1:WD_W];
    assign mst_writedata = stage_out[WD_W-1:0];

endmodule

// File: rtl/st2mm_chk.sv
module st2mm_chk #(
    parameter int DATA_W  = 32,
    parameter int EMPTY_W = 2,
    parameter int ERR_W   = 2,
    parameter int CHAN_W  = 4,
    parameter int ADDR_W  = 8,
    parameter bit REG_OUT = 1'b1,
    localparam int WD_W   = DATA_W + 2 + EMPTY_W + ERR_W + CHAN_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              snk_valid,
    input logic              snk_ready,
    input logic [DATA_W-1:0] snk_data,
    input logic [CHAN_W-1:0] snk_channel,
    input logic              mst_write,
    input logic [ADDR_W-1:0] mst_address,
    input logic [WD_W-1:0]   mst_writedata,
    input logic              mst_waitrequest
);
    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mst_write && mst_waitrequest |=>
            mst_write && $stable(mst_address) && $stable(mst_writedata));

    // R2
    ready_tracks_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mst_write |-> (snk_ready == !mst_waitrequest));

    generate
        if (REG_OUT) begin : g_reg_chk
            // R7
            idle_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !mst_write |-> snk_ready);

            // R1 R3 R4
            beat_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
                snk_valid && snk_ready |=>
                    mst_write
                    && (mst_writedata[DATA_W-1:0] == $past(snk_data))
                    && (mst_address == ADDR_W'($past(snk_channel))));

            // R8
            reset_quiet_chk: assert property (@(posedge clk)
                !rst_n |=> !mst_write);
        end
    endgenerate

endmodule

bind st2mm_wr_bridge st2mm_chk #(
    .DATA_W (DATA_W),
    .EMPTY_W(EMPTY_W),
    .ERR_W  (ERR_W),
    .CHAN_W (CHAN_W),
    .ADDR_W (ADDR_W),
    .REG_OUT(REG_OUT)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .snk_valid      (snk_valid),
    .snk_ready      (snk_ready),
    .snk_data       (snk_data),
    .snk_channel    (snk_channel),
    .mst_write      (mst_write),
    .mst_address    (mst_address),
    .mst_writedata  (mst_writedata),
    .mst_waitrequest(mst_waitrequest)
);

// File: tb/sim_st2mm_wr_bridge.sv
module sim_st2mm_wr_bridge;
    localparam int DW = 32;
    localparam int EW = 2;
    localparam int RW = 2;
    localparam int CW = 4;
    localparam int AW = 8;
    localparam int WW = DW + 2 + EW + RW + CW;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz
    logic rst_n;

    // Registered instance signals
    logic          s_valid, s_ready, s_sop, s_eop, m_write, m_wait;
    logic [DW-1:0] s_data;
    logic [EW-1:0] s_empty;
    logic [RW-1:0] s_err;
    logic [CW-1:0] s_chan;
    logic [AW-1:0] m_addr;
    logic [WW-1:0] m_wd;

    // Pass-through instance signals
    logic          p_valid, p_ready, p_sop, p_eop, q_write, q_wait;
    logic [DW-1:0] p_data;
    logic [EW-1:0] p_empty;
    logic [RW-1:0] p_err;
    logic [CW-1:0] p_chan;
    logic [AW-1:0] q_addr;
    logic [WW-1:0] q_wd;

    st2mm_wr_bridge #(.DATA_W(DW), .EMPTY_W(EW), .ERR_W(RW), .CHAN_W(CW),
                      .ADDR_W(AW), .REG_OUT(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .snk_valid(s_valid), .snk_ready(s_ready),
        .snk_data(s_data), .snk_sop(s_sop), .snk_eop(s_eop), .snk_empty(s_empty),
        .snk_error(s_err), .snk_channel(s_chan), .mst_write(m_write),
        .mst_address(m_addr), .mst_writedata(m_wd), .mst_waitrequest(m_wait));

    st2mm_wr_bridge #(.DATA_W(DW), .EMPTY_W(EW), .ERR_W(RW), .CHAN_W(CW),
                      .ADDR_W(AW), .REG_OUT(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .snk_valid(p_valid), .snk_ready(p_ready),
        .snk_data(p_data), .snk_sop(p_sop), .snk_eop(p_eop), .snk_empty(p_empty),
        .snk_error(p_err), .snk_channel(p_chan), .mst_write(q_write),
        .mst_address(q_addr), .mst_writedata(q_wd), .mst_waitrequest(q_wait));

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Beat contents computed from a beat id
    function automatic logic [DW-1:0] b_data(input logic [2:0] id);
        return 32'hC0DE0000 + 32'(id) * 32'h00011111;
    endfunction
    function automatic logic [CW-1:0] b_chan(input logic [2:0] id);
        return 4'(32'(id) * 5 + 1);
    endfunction
    function automatic logic [RW-1:0] b_err(input logic [2:0] id);
        return 2'(32'(id) + 1);
    endfunction

    // R5: expected write word, fields from the LSB up
    function automatic logic [WW-1:0] b_word(input logic [2:0] id);
        return {b_chan(id), b_err(id), id[2:1], id[1], id[0], b_data(id)};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic drive_s(input logic v, input logic [2:0] id, input logic w);
        s_valid = v;
        s_data  = b_data(id);
        s_sop   = id[0];
        s_eop   = id[1];
        s_empty = id[2:1];
        s_err   = b_err(id);
        s_chan  = b_chan(id);
        m_wait  = w;
    endtask

    task automatic drive_p(input logic v, input logic [2:0] id, input logic w);
        p_valid = v;
        p_data  = b_data(id);
        p_sop   = id[0];
        p_eop   = id[1];
        p_empty = id[2:1];
        p_err   = b_err(id);
        p_chan  = b_chan(id);
        q_wait  = w;
    endtask

    // Per-cycle vector: {wait, valid, beat id[2:0], exp write, exp ready, exp beat id[2:0]}
    localparam logic [9:0] VEC [12] = '{
        10'b0_1_000_0_1_000,  // load A
        10'b1_1_001_1_0_000,  // stall on A
        10'b1_1_001_1_0_000,  // stall again
        10'b0_1_001_1_1_000,  // A completes, reload B
        10'b0_1_010_1_1_001,  // B completes, reload C (back to back)
        10'b0_0_011_1_1_010,  // C completes, drain
        10'b1_0_011_0_1_000,  // empty, ready despite wait
        10'b1_1_011_0_1_000,  // empty takes D while slave stalls
        10'b1_1_100_1_0_011,  // D stalled, E waits
        10'b0_1_100_1_1_011,  // D completes, reload E
        10'b0_0_000_1_1_100,  // E completes, drain
        10'b0_0_000_0_1_000   // idle
    };

    initial begin
        rst_n = 1'b0;
        drive_s(1'b0, 3'd0, 1'b0);
        drive_p(1'b0, 3'd0, 1'b0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        chk("R8", "write in reset", 64'(m_write), 64'd0);
        chk("R8", "ready in reset", 64'(s_ready), 64'd1);
        rst_n = 1'b1;

        // Table walk on the registered instance (R1 R2 R3 R4 R5 R6 R7 R10)
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            drive_s(VEC[i][8], VEC[i][7:5], VEC[i][9]);
            #1;
            chk("R1", $sformatf("write step %0d", i), 64'(m_write), 64'(VEC[i][4]));
            chk("R7", $sformatf("ready step %0d", i), 64'(s_ready), 64'(VEC[i][3]));
            if (VEC[i][4]) begin
                chk("R4", $sformatf("address step %0d", i), 64'(m_addr),
                    64'(b_chan(VEC[i][2:0])));
                chk("R5", $sformatf("writedata step %0d", i), 64'(m_wd),
                    64'(b_word(VEC[i][2:0])));
                chk("R3", $sformatf("payload step %0d", i), 64'(m_wd[DW-1:0]),
                    64'(b_data(VEC[i][2:0])));
            end
        end

        // R8: reset while a write is stalled drops the held beat at once
        @(negedge clk);
        drive_s(1'b1, 3'd5, 1'b1);
        @(negedge clk);
        drive_s(1'b0, 3'd5, 1'b1);
        #1;
        chk("R6", "stalled write held", 64'(m_write), 64'd1);
        chk("R6", "stalled word held", 64'(m_wd), 64'(b_word(3'd5)));
        rst_n = 1'b0;
        #1;
        chk("R8", "write after mid reset", 64'(m_write), 64'd0);
        chk("R8", "ready after mid reset", 64'(s_ready), 64'd1);
        @(negedge clk);
        rst_n = 1'b1;
        drive_s(1'b0, 3'd0, 1'b0);

        // Pass-through instance (R9 R1 R2 R6)
        @(negedge clk);
        drive_p(1'b1, 3'd2, 1'b0);
        #1;
        chk("R9", "same-cycle write", 64'(q_write), 64'd1);
        chk("R9", "same-cycle address", 64'(q_addr), 64'(b_chan(3'd2)));
        chk("R9", "same-cycle word", 64'(q_wd), 64'(b_word(3'd2)));
        chk("R2", "ready with no wait", 64'(p_ready), 64'd1);
        @(negedge clk);
        drive_p(1'b1, 3'd3, 1'b1);
        #1;
        chk("R2", "ready under wait", 64'(p_ready), 64'd0);
        chk("R1", "write under wait", 64'(q_write), 64'd1);
        @(negedge clk);
        #1;
        chk("R6", "pass-through word held", 64'(q_wd), 64'(b_word(3'd3)));
        @(negedge clk);
        drive_p(1'b1, 3'd3, 1'b0);
        #1;
        chk("R2", "ready after wait", 64'(p_ready), 64'd1);
        @(negedge clk);
        drive_p(1'b0, 3'd3, 1'b0);
        #1;
        chk("R1", "write follows idle valid", 64'(q_write), 64'd0);
        chk("R9", "idle ready without wait", 64'(p_ready), 64'd1);
        @(negedge clk);
        drive_p(1'b0, 3'd3, 1'b1);
        #1;
        chk("R9", "idle ready under wait", 64'(p_ready), 64'd0);
        @(negedge clk);
        drive_p(1'b0, 3'd0, 1'b0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R8 watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule